// File: doc/BRIEF.md
# I/Q Output Conditioner With Imbalance Correction

This block sits at the end of a transmit datapath, just before a pair of digital-to-analog converters. It takes one complex sample per valid cycle, passes it through a real 2×2 matrix that cancels gain and phase mismatch between the in-phase and quadrature paths, and adds a signed DC offset per channel in quarter-LSB steps. It then clamps each channel to the signed output range and can coarsen the output to fewer significant bits.

A small write-only host port loads the four matrix terms, the two offsets and a control word. The matrix terms first land in holding registers. The active set is replaced in one step when the final matrix term is written, so the datapath never mixes old and new terms. Each channel has a sticky flag that records any clamped sample until the host pulses a clear. A bypass bit routes the raw input to the output with the same latency.

Top module: `iq_out_conditioner`

## Requirements
- R1: After reset, out_vld, out_i, out_q and sat_flag are all 0. The active matrix is the identity (diagonal terms 16384, cross terms 0), both offsets are 0, the width field is 18 and bypass is off, so a sample leaves unchanged.
- R2: Matrix terms are signed 16-bit with 14 fraction bits. Address 2 (I into I) and address 3 (Q into I) feed the I output. Address 4 (I into Q) and address 5 (Q into Q) feed the Q output. Each output sums its two products at full precision.
- R3: Each product sum is rounded half-up to quarter-LSB units (add 2^11, arithmetic shift right by 12). The signed 16-bit offset in quarter-LSB units is then added (address 0 for I, address 1 for Q). The result is rounded half-up to whole LSBs (add 2, arithmetic shift right by 2).
- R4: Each result is clamped to the signed 18-bit range, -131072 to 131071.
- R5: Writes to addresses 2, 3 and 4 do not change the output. A write to address 5 makes all four latest terms active together, from the next input cycle onward.
- R6: A sat_flag bit (bit 0 for I, bit 1 for Q) rises on the same clock edge that presents a clamped sample on that channel. It stays high until host_clr is pulsed.
- R7: host_clr drops both flags on the next edge. A clamped sample presented on that same edge keeps its flag high.
- R8: Control word at address 6, bits 4:0, is a width W. For W from 1 to 18, the low 18-W bits of each non-bypassed output are forced to 0 after clamping. Any other W gives the full 18 bits.
- R9: Control bit 8 at address 6 selects bypass: the outputs equal the inputs, the latency is unchanged, and the flags do not change.
- R10: out_vld rises exactly two clock edges after a cycle with in_vld high. The data outputs change only when out_vld is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_we | input | 1 | Register write strobe |
| host_addr | input | 3 | Register address |
| host_wdata | input | 16 | Register write data |
| host_clr | input | 1 | Clear pulse for both saturation flags |
| in_vld | input | 1 | Input sample valid |
| in_i | input | 18 | Signed in-phase input |
| in_q | input | 18 | Signed quadrature input |
| out_vld | output | 1 | Output sample valid |
| out_i | output | 18 | Signed in-phase output |
| out_q | output | 18 | Signed quadrature output |
| sat_flag | output | 2 | Sticky clamp flags, bit 0 for I, bit 1 for Q |

## Verification
A wrong active coefficient, whether a holding register copied too early or a cross term wired to the wrong channel, shows up as a wrong output value two edges after the first sample that uses it. A rounding or offset error shifts outputs by one LSB near half-way points, so the sweeps include small offsets and sums that land on exact halves. A broken sticky or clear path shows at sat_flag one edge after the clamped sample or the clear pulse. A faulty bypass or width path shows on the very next valid output.

// File: rtl/iq_out_conditioner.sv
module iq_out_conditioner #(
  parameter int IN_W   = 18,
  parameter int OUT_W  = 18,
  parameter int COEF_W = 16,
  parameter int COEF_F = 14,
  parameter int FX     = 2,
  parameter int OFS_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    host_we,
  input  logic [2:0]              host_addr,
  input  logic [15:0]             host_wdata,
  input  logic                    host_clr,
  input  logic                    in_vld,
  input  logic signed [IN_W-1:0]  in_i,
  input  logic signed [IN_W-1:0]  in_q,
  output logic                    out_vld,
  output logic signed [OUT_W-1:0] out_i,
  output logic signed [OUT_W-1:0] out_q,
  output logic [1:0]              sat_flag
);
  localparam int PROD_W = IN_W + COEF_W;
  localparam int SUM_W  = PROD_W + 1;
  localparam int EXT_W  = SUM_W + 2;
  localparam int RND    = COEF_F - FX;
  localparam int WID_W  = $clog2(OUT_W + 1);
  localparam logic signed [COEF_W-1:0] UNITY = COEF_W'(1 << COEF_F);
  localparam logic signed [EXT_W-1:0] MAXV = EXT_W'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
  localparam logic signed [EXT_W-1:0] MINV = -MAXV - EXT_W'(1);

  logic signed [COEF_W-1:0] m_ii, m_qi, m_iq, m_qq;
  logic signed [COEF_W-1:0] k_ii, k_qi, k_iq, k_qq;
  logic signed [OFS_W-1:0]  ofs_i, ofs_q;
  logic [4:0]               wfield;
  logic                     byp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ii <= UNITY; m_qi <= '0; m_iq <= '0; m_qq <= UNITY;
      k_ii <= UNITY; k_qi <= '0; k_iq <= '0; k_qq <= UNITY;
      ofs_i <= '0; ofs_q <= '0;
      wfield <= 5'(OUT_W); byp <= 1'b0;
    end else if (host_we) begin
      case (host_addr)
        3'd0: ofs_i <= OFS_W'(host_wdata);
        3'd1: ofs_q <= OFS_W'(host_wdata);
        3'd2: m_ii <= COEF_W'(host_wdata);
        3'd3: m_qi <= COEF_W'(host_wdata);
        3'd4: m_iq <= COEF_W'(host_wdata);
        3'd5: begin
          m_qq <= COEF_W'(host_wdata);
          k_ii <= m_ii; k_qi <= m_qi; k_iq <= m_iq;
          k_qq <= COEF_W'(host_wdata);
        end
        3'd6: begin
          wfield <= host_wdata[4:0];
          byp    <= host_wdata[8];
        end
        default: ;
      endcase
    end
  end

  // stage 1: raw sample and four products
  logic                     v1, b1;
  logic signed [IN_W-1:0]   x1_i, x1_q;
  logic signed [PROD_W-1:0] p_ii, p_qi, p_iq, p_qq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0; b1 <= 1'b0;
      x1_i <= '0; x1_q <= '0;
      p_ii <= '0; p_qi <= '0; p_iq <= '0; p_qq <= '0;
    end else begin
      v1 <= in_vld;
      if (in_vld) begin
        b1   <= byp;
        x1_i <= in_i;
        x1_q <= in_q;
        p_ii <= in_i * k_ii;
        p_qi <= in_q * k_qi;
        p_iq <= in_i * k_iq;
        p_qq <= in_q * k_qq;
      end
    end
  end

  // stage 2: sum, round, offset, round, clamp, width
  function automatic logic [OUT_W:0] condition(input logic signed [SUM_W-1:0] acc,
                                               input logic signed [OFS_W-1:0] ofs);
    logic signed [EXT_W-1:0] t;
    logic sat;
    t = EXT_W'(acc) + EXT_W'(64'sd1 <<< (RND - 1));
    t = t >>> RND;
    t = t + EXT_W'(ofs) + EXT_W'(64'sd1 <<< (FX - 1));
    t = t >>> FX;
    sat = (t > MAXV) || (t < MINV);
    if (t > MAXV) t = MAXV;
    else if (t < MINV) t = MINV;
    return {sat, t[OUT_W-1:0]};
  endfunction

  logic signed [SUM_W-1:0] acc_i, acc_q;
  logic [OUT_W:0]          c_i, c_q;
  logic [WID_W-1:0]        wsel;
  logic [OUT_W-1:0]        keep;
  logic                    sat_i, sat_q;

  assign acc_i = SUM_W'(p_ii) + SUM_W'(p_qi);
  assign acc_q = SUM_W'(p_iq) + SUM_W'(p_qq);
  assign c_i   = condition(acc_i, ofs_i);
  assign c_q   = condition(acc_q, ofs_q);
  assign wsel  = (wfield == 5'd0 || int'(wfield) > OUT_W) ? WID_W'(OUT_W) : WID_W'(wfield);
  assign keep  = {OUT_W{1'b1}} << (OUT_W - int'(wsel));
  assign sat_i = v1 && !b1 && c_i[OUT_W];
  assign sat_q = v1 && !b1 && c_q[OUT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld <= 1'b0; out_i <= '0; out_q <= '0; sat_flag <= '0;
    end else begin
      out_vld  <= v1;
      sat_flag <= (sat_flag & {2{!host_clr}}) | {sat_q, sat_i};
      if (v1) begin
        out_i <= b1 ? OUT_W'(x1_i) : (c_i[OUT_W-1:0] & keep);
        out_q <= b1 ? OUT_W'(x1_q) : (c_q[OUT_W-1:0] & keep);
      end
    end
  end

  // R10
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    v1 |=> out_vld);
  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !v1 |=> ($stable(out_i) && $stable(out_q) && !out_vld));
  // R5
  shadow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_we && host_addr == 3'd5) |=> ($stable(k_ii) && $stable(k_qi) && $stable(k_iq) && $stable(k_qq)));
  // R6
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_flag[0] && !host_clr) |=> sat_flag[0]);
  // R7
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_clr && !sat_i && !sat_q) |=> (sat_flag == 2'b00));
endmodule

// File: tb/tb_iq_out_conditioner.sv
module tb_iq_out_conditioner;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_we = 1'b0;
  logic [2:0] host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic host_clr = 1'b0;
  logic in_vld = 1'b0;
  logic signed [17:0] in_i = '0, in_q = '0;
  logic out_vld;
  logic signed [17:0] out_i, out_q;
  logic [1:0] sat_flag;

  int total = 0, bad = 0;
  longint k[4];
  longint ofs[2];
  int width = 18;
  bit bypass = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  iq_out_conditioner dut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_clr(host_clr), .in_vld(in_vld),
    .in_i(in_i), .in_q(in_q), .out_vld(out_vld), .out_i(out_i),
    .out_q(out_q), .sat_flag(sat_flag));

  task automatic check(input string req, input longint got, input longint exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d expected=%0d", req, got, exp);
    end
  endtask

  function automatic void model(input longint x0, input longint x1, input longint c0,
                                input longint c1, input longint o,
                                output longint v, output bit s);
    longint acc, r;
    acc = c0 * x0 + c1 * x1;
    r = (acc + 2048) >>> 12;
    r = (r + o + 2) >>> 2;
    s = 1'b0;
    if (r > 131071) begin r = 131071; s = 1'b1; end
    else if (r < -131072) begin r = -131072; s = 1'b1; end
    if (width >= 1 && width <= 18) r = r & ~((longint'(1) << (18 - width)) - 1);
    v = r;
  endfunction

  task automatic wr(input int a, input longint d);
    @(negedge clk);
    host_we = 1'b1; host_addr = 3'(a); host_wdata = 16'(d);
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic clr_flags();
    @(negedge clk);
    host_clr = 1'b1;
    @(negedge clk);
    host_clr = 1'b0;
  endtask

  task automatic run(input longint xi, input longint xq, output bit si, output bit sq);
    longint ei, eq;
    @(negedge clk);
    in_vld = 1'b1; in_i = 18'(xi); in_q = 18'(xq);
    @(negedge clk);
    in_vld = 1'b0;
    @(negedge clk);
    if (bypass) begin
      ei = xi; eq = xq; si = 1'b0; sq = 1'b0;
    end else begin
      model(xi, xq, k[0], k[1], ofs[0], ei, si);
      model(xi, xq, k[2], k[3], ofs[1], eq, sq);
    end
    check("R10 out_vld", longint'(out_vld), 1);
    check("R2/R3/R4/R8/R9 out_i", longint'(out_i), ei);
    check("R2/R3/R4/R8/R9 out_q", longint'(out_q), eq);
  endtask

  task automatic sweep();
    longint xs[9] = '{-131072, -131071, -1, 0, 1, 65535, 131071, 12345, -54321};
    bit si, sq;
    foreach (xs[a]) begin
      foreach (xs[b]) begin
        run(xs[a], xs[b], si, sq);
        // R6 flag reflects the clamp just presented
        check("R6 sat_flag", longint'(sat_flag), longint'({sq, si}));
        if (si || sq) clr_flags();
      end
    end
  endtask

  task automatic load(input longint a, input longint b, input longint c, input longint d);
    wr(2, a); wr(3, b); wr(4, c); wr(5, d);
    k[0] = a; k[1] = b; k[2] = c; k[3] = d;
  endtask

  initial begin
    #(CLK_P * 150000);
    bad++;
    $display("FAIL watchdog expired got=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit si, sq;
    k[0] = 16384; k[1] = 0; k[2] = 0; k[3] = 16384;
    ofs[0] = 0; ofs[1] = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 out_vld", longint'(out_vld), 0);
    check("R1 out_i", longint'(out_i), 0);
    check("R1 out_q", longint'(out_q), 0);
    check("R1 sat_flag", longint'(sat_flag), 0);
    rst_n = 1'b1;
    run(77777, -33333, si, sq);
    check("R1 identity i", longint'(out_i), 77777);
    check("R1 identity q", longint'(out_q), -33333);

    // R10 nothing valid after a single edge
    @(negedge clk);
    in_vld = 1'b1; in_i = 18'sd5; in_q = 18'sd6;
    @(negedge clk);
    in_vld = 1'b0;
    check("R10 early out_vld", longint'(out_vld), 0);
    @(negedge clk);
    check("R10 on time", longint'(out_vld), 1);
    @(negedge clk);
    check("R10 hold vld low", longint'(out_vld), 0);
    check("R10 hold data", longint'(out_i), 5);

    // R2 R3 R4 sweeps over coefficient and offset sets
    for (int cs = 0; cs < 4; cs++) begin
      case (cs)
        0: load(16384, 0, 0, 16384);
        1: load(17384, -700, 500, 15184);
        2: load(32767, 32767, -32768, 32767);
        default: load(-16384, 8192, 8192, 0);
      endcase
      for (int os = 0; os < 3; os++) begin
        case (os)
          0: begin ofs[0] = 0; ofs[1] = 0; end
          1: begin ofs[0] = 3; ofs[1] = -3; end
          default: begin ofs[0] = -6; ofs[1] = 401; end
        endcase
        wr(0, ofs[0]); wr(1, ofs[1]);
        sweep();
      end
    end

    // R3 half-way rounding: 0.5 LSB from matrix, plus offsets
    load(8192, 0, 0, 8192);
    ofs[0] = 1; ofs[1] = -1; wr(0, 1); wr(1, -1);
    run(1, 3, si, sq);
    run(-1, -3, si, sq);

    // R5 holding registers do not act until last term
    wr(2, 4096); wr(3, 4096); wr(4, -4096);
    run(1000, 2000, si, sq);
    check("R5 before commit i", longint'(out_i), 500);
    wr(5, 16384);
    k[0] = 4096; k[1] = 4096; k[2] = -4096; k[3] = 16384;
    run(1000, 2000, si, sq);
    check("R5 after commit i", longint'(out_i), 750);
    check("R5 after commit q", longint'(out_q), 1750);

    // R7 clear in the same edge as a clamp keeps the flag
    ofs[0] = 0; ofs[1] = 0; wr(0, 0); wr(1, 0);
    load(32767, 32767, 0, 16384);
    clr_flags();
    @(negedge clk);
    in_vld = 1'b1; in_i = 18'sd131071; in_q = 18'sd131071;
    @(negedge clk);
    in_vld = 1'b0; host_clr = 1'b1;
    @(negedge clk);
    host_clr = 1'b0;
    check("R7 clamp wins over clear", longint'(sat_flag), 1);
    @(negedge clk);
    check("R6 flag sticks", longint'(sat_flag), 1);
    clr_flags();
    check("R7 clear drops flag", longint'(sat_flag), 0);

    // R8 width control
    load(17384, -700, 500, 15184);
    width = 10; wr(6, 10);
    sweep();
    width = 0; wr(6, 0);
    run(12345, -54321, si, sq);
    width = 31; wr(6, 31);
    run(-12345, 54321, si, sq);
    width = 1; wr(6, 1);
    run(-5, 131071, si, sq);

    // R9 bypass, flags untouched, width ignored
    clr_flags();
    bypass = 1'b1; width = 10; wr(6, 256 + 10);
    load(32767, 32767, 32767, 32767);
    run(131071, -131072, si, sq);
    check("R9 no flags", longint'(sat_flag), 0);
    run(-3, 7, si, sq);
    bypass = 1'b0; width = 18; wr(6, 18);
    run(3, 7, si, sq);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule